// File: doc/BRIEF.md
# Parser Stage Match-Action Unit

This block is one step of a chained packet-header parser. The step before it hands over a parser state value and three data fields that were already pulled out of the header. The block compares that key with a ternary table and picks the lowest-numbered enabled entry that matches. It then returns the stored pair of action words. The primary word tells the next step what to do: the next state, how far to move the pointer, what to capture, and whether parsing is finished. The secondary word carries an error level and code, plus the data-pointer offsets for the next step.

A simple write port programs the table. For each entry it writes the two match planes and the two action words. It also writes a bitmap that disables entries one by one, and a control word. The control word holds a stage enable and the error code to report when nothing matches. Every accepted input beat gives one registered result. The result is held on a valid/ready handshake until the consumer takes it.

Top module: `pstage_match`

## Requirements
- R1: After reset, o_valid is 0 and i_ready is 1. All entries are disabled, the stage enable is 0 and the default error code is 0, so any lookup made before configuration returns a miss.
- R2: The key is {dp2, dp1, dp0, state}, with state in the low bits. For a key bit n, an entry matches only if (key[n]=1 and plane0[n]=1) is false and (key[n]=0 and plane1[n]=1) is false. Both planes 0 makes the bit a don't-care.
- R3: Writes go through cfg_addr. With bit AW-1 clear, bits [IW+1:2] select the entry and bits [1:0] select the register: 0 is plane1, 1 is plane0, 2 is the primary action, 3 is the secondary action. With bit AW-1 set, register 0 is the control word and register k+1 is disable word k.
- R4: Bit i%64 of disable word i/64 set to 1 removes entry i from matching. Writing a mask that has bits below N cleared and bits N and up set enables exactly entries 0..N-1, including when N crosses the 64-entry word boundary.
- R5: Control bit 0 is the stage enable. While it is 0, every lookup is a miss whatever the table holds. Control bits [15:8] hold the default error code.
- R6: When several enabled entries match, the one with the lowest index is reported.
- R7: On a hit, o_hit is 1, o_idx is the entry, and o_act0/o_act1 are the stored action words. o_done equals bit 17 of the primary word, and o_err_code equals bits [11:4] of the secondary word.
- R8: On a miss, o_hit is 0, o_idx is 0, and o_act0 has only bit 17 (parse done) set. o_act1 is the default error code placed at [11:4] with all other bits 0, so o_done is 1 and o_err_code is the default code.
- R9: A key bit with both planes set to 1 never matches, so that entry never hits.
- R10: i_ready is low exactly while a result is held with o_ready low. While held, all outputs stay stable. Each accepted beat produces exactly one result, one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | IW+3 | Configuration register address |
| cfg_wdata | input | 64 | Configuration write data |
| i_valid | input | 1 | Input key valid |
| i_ready | output | 1 | Block can accept a key |
| i_state | input | ST_W | Current parser state |
| i_dp0 | input | DP_W | Data field 0 from the previous step |
| i_dp1 | input | DP_W | Data field 1 from the previous step |
| i_dp2 | input | DP_W | Data field 2 from the previous step |
| o_valid | output | 1 | Result valid |
| o_ready | input | 1 | Consumer takes the result |
| o_hit | output | 1 | An enabled entry matched |
| o_idx | output | IW | Index of the winning entry |
| o_act0 | output | 64 | Primary action word |
| o_act1 | output | 64 | Secondary action word |
| o_done | output | 1 | Parse-done flag of the result |
| o_err_code | output | 8 | Error code of the result |

## Verification
The hardest case to reach from the ports is a lookup where several enabled entries match at once and the winner depends on both priority and the disable bitmap across the word boundary. Reaching it needs a crowded table. The random phase fills all 128 entries with values and masks drawn from a tiny key space and mostly don't-care masks. It also draws random disable words, so overlapping matches are common. Directed cases cover the rest: the enable-first-N mask at N=70, an entry with a contradictory bit, and a result held under back-pressure while a second key waits.

// File: rtl/pstage_match.sv
module pstage_match #(
  parameter int N_ENT = 128,
  parameter int ST_W  = 8,
  parameter int DP_W  = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [$clog2(N_ENT)+2:0]      cfg_addr,
  input  logic [63:0]                   cfg_wdata,
  input  logic                          i_valid,
  output logic                          i_ready,
  input  logic [ST_W-1:0]               i_state,
  input  logic [DP_W-1:0]               i_dp0,
  input  logic [DP_W-1:0]               i_dp1,
  input  logic [DP_W-1:0]               i_dp2,
  output logic                          o_valid,
  input  logic                          o_ready,
  output logic                          o_hit,
  output logic [$clog2(N_ENT)-1:0]      o_idx,
  output logic [63:0]                   o_act0,
  output logic [63:0]                   o_act1,
  output logic                          o_done,
  output logic [7:0]                    o_err_code
);
  localparam int KW = ST_W + 3 * DP_W;
  localparam int IW = $clog2(N_ENT);
  localparam int DW = (N_ENT + 63) / 64;
  localparam int AW = IW + 3;
  localparam int DONE_B = 17;
  localparam logic [63:0] MISS_A0 = 64'd1 << DONE_B;

  logic [KW-1:0] c1 [N_ENT];
  logic [KW-1:0] c0 [N_ENT];
  logic [63:0]   a0 [N_ENT];
  logic [63:0]   a1 [N_ENT];
  logic [63:0]   dis [DW];
  logic          stage_en;
  logic [7:0]    def_code;

  wire          glb  = cfg_addr[AW-1];
  wire [IW-1:0] ent  = cfg_addr[IW+1:2];
  wire [1:0]    sel  = cfg_addr[1:0];
  wire [IW+1:0] greg = cfg_addr[IW+1:0];

  wire [KW-1:0] key = {i_dp2, i_dp1, i_dp0, i_state};

  logic [N_ENT-1:0] live;
  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    assign live[g] = !dis[g/64][g%64] && (((key & c0[g]) | (~key & c1[g])) == '0);
  end

  logic          hit;
  logic [IW-1:0] idx;
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (stage_en && live[i]) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_ENT; i++) begin
        c1[i] <= '0;
        c0[i] <= '0;
        a0[i] <= '0;
        a1[i] <= '0;
      end
      for (int k = 0; k < DW; k++) dis[k] <= '1;
      stage_en <= 1'b0;
      def_code <= '0;
    end else if (cfg_we) begin
      if (glb) begin
        if (greg == '0) begin
          stage_en <= cfg_wdata[0];
          def_code <= cfg_wdata[15:8];
        end
        for (int k = 0; k < DW; k++)
          if (greg == (IW+2)'(k + 1)) dis[k] <= cfg_wdata;
      end else if (int'(ent) < N_ENT) begin
        case (sel)
          2'd0: c1[ent] <= cfg_wdata[KW-1:0];
          2'd1: c0[ent] <= cfg_wdata[KW-1:0];
          2'd2: a0[ent] <= cfg_wdata;
          default: a1[ent] <= cfg_wdata;
        endcase
      end
    end
  end

  assign i_ready = !o_valid || o_ready;
  wire take = i_valid && i_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_valid <= 1'b0;
      o_hit   <= 1'b0;
      o_idx   <= '0;
      o_act0  <= '0;
      o_act1  <= '0;
    end else begin
      if (take) o_valid <= 1'b1;
      else if (o_ready) o_valid <= 1'b0;
      if (take) begin
        o_hit  <= hit;
        o_idx  <= idx;
        o_act0 <= hit ? a0[idx] : MISS_A0;
        o_act1 <= hit ? a1[idx] : (64'(def_code) << 4);
      end
    end
  end

  assign o_done     = o_act0[DONE_B];
  assign o_err_code = o_act1[11:4];
endmodule

// File: rtl/pstage_match_chk.sv
module pstage_match_chk #(parameter int IW = 7) (
  input logic          clk,
  input logic          rst_n,
  input logic          i_valid,
  input logic          i_ready,
  input logic          o_valid,
  input logic          o_ready,
  input logic          o_hit,
  input logic [IW-1:0] o_idx,
  input logic [63:0]   o_act0,
  input logic          o_done,
  input logic          stage_en
);
  a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !o_valid);
  a_r5_off_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (i_valid && i_ready && !stage_en) |=> !o_hit);
  a_r8_miss_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !o_hit) |-> (o_done && o_idx == '0));
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !o_ready) |=> (o_valid && $stable(o_act0) && $stable(o_idx) && $stable(o_hit)));
  a_r10_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (i_valid && i_ready) |=> o_valid);
  a_r10_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !o_ready) |-> !i_ready);
endmodule

bind pstage_match pstage_match_chk #(.IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .i_valid(i_valid), .i_ready(i_ready),
  .o_valid(o_valid), .o_ready(o_ready), .o_hit(o_hit), .o_idx(o_idx),
  .o_act0(o_act0), .o_done(o_done), .stage_en(stage_en)
);

// File: tb/pstage_match_bench.sv
module pstage_match_bench;
  localparam int N = 128;
  localparam int IW = 7;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [IW+2:0] cfg_addr = '0;
  logic [63:0] cfg_wdata = '0;
  logic i_valid = 0, o_ready = 1;
  logic [7:0] i_state = '0;
  logic [15:0] i_dp0 = '0, i_dp1 = '0, i_dp2 = '0;
  logic i_ready, o_valid, o_hit, o_done;
  logic [IW-1:0] o_idx;
  logic [63:0] o_act0, o_act1;
  logic [7:0] o_err_code;

  pstage_match u_pstage_match (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .i_valid(i_valid), .i_ready(i_ready), .i_state(i_state), .i_dp0(i_dp0), .i_dp1(i_dp1),
    .i_dp2(i_dp2), .o_valid(o_valid), .o_ready(o_ready), .o_hit(o_hit), .o_idx(o_idx),
    .o_act0(o_act0), .o_act1(o_act1), .o_done(o_done), .o_err_code(o_err_code));

  always #10 clk = ~clk;

  int ntot = 0, nbad = 0;
  bit finished = 0;

  logic [55:0] m_c1 [N];
  logic [55:0] m_c0 [N];
  logic [63:0] m_a0 [N];
  logic [63:0] m_a1 [N];
  logic [63:0] m_dis [2];
  bit m_en = 0;
  logic [7:0] m_def = '0;

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    ntot++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [55:0] pk(logic [7:0] st, logic [15:0] d0, logic [15:0] d1, logic [15:0] d2);
    return {d2, d1, d0, st};
  endfunction

  function automatic logic [63:0] first_n(int n, int w);
    logic [63:0] m;
    for (int b = 0; b < 64; b++) m[b] = ((w * 64 + b) >= n);
    return m;
  endfunction

  task automatic wr(logic [IW+2:0] a, logic [63:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic ent_raw(int i, logic [55:0] p1, logic [55:0] p0, logic [63:0] x0, logic [63:0] x1);
    wr({1'b0, IW'(i), 2'd0}, 64'(p1));
    wr({1'b0, IW'(i), 2'd1}, 64'(p0));
    wr({1'b0, IW'(i), 2'd2}, x0);
    wr({1'b0, IW'(i), 2'd3}, x1);
    m_c1[i] = p1; m_c0[i] = p0; m_a0[i] = x0; m_a1[i] = x1;
  endtask

  task automatic ent(int i, logic [55:0] v, logic [55:0] m, logic [63:0] x0, logic [63:0] x1);
    ent_raw(i, v & m, ~v & m, x0, x1);
  endtask

  task automatic set_dis(int w, logic [63:0] d);
    wr({1'b1, (IW+2)'(w + 1)}, d);
    m_dis[w] = d;
  endtask

  task automatic set_ctl(bit en, logic [7:0] dc);
    wr({1'b1, (IW+2)'(0)}, {48'd0, dc, 7'd0, en});
    m_en = en; m_def = dc;
  endtask

  task automatic lk(logic [55:0] k, string tag);
    bit eh = 0;
    int ei = 0;
    logic [63:0] e0, e1;
    for (int i = N - 1; i >= 0; i--)
      if (m_en && !m_dis[i/64][i%64] && (((k & m_c0[i]) | (~k & m_c1[i])) == '0)) begin
        eh = 1; ei = i;
      end
    e0 = eh ? m_a0[ei] : (64'd1 << 17);
    e1 = eh ? m_a1[ei] : (64'(m_def) << 4);
    @(negedge clk);
    i_valid = 1; {i_dp2, i_dp1, i_dp0, i_state} = k;
    @(posedge clk);
    @(negedge clk);
    i_valid = 0;
    chk({tag, " valid"}, 64'(o_valid), 64'd1);
    chk({tag, " hit"}, 64'(o_hit), 64'(eh));
    chk({tag, " idx"}, 64'(o_idx), 64'(eh ? ei : 0));
    chk({tag, " act0"}, o_act0, e0);
    chk({tag, " act1"}, o_act1, e1);
    chk({tag, " done"}, 64'(o_done), 64'(e0[17]));
    chk({tag, " err"}, 64'(o_err_code), 64'(e1[11:4]));
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      ntot++; nbad++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("test done: total=%0d bad=%0d", ntot, nbad);
      $finish;
    end
  end

  initial begin
    logic [55:0] ka, kb, v, m;
    logic [63:0] hold0;
    for (int i = 0; i < N; i++) begin
      m_c1[i] = '0; m_c0[i] = '0; m_a0[i] = '0; m_a1[i] = '0;
    end
    m_dis[0] = '1; m_dis[1] = '1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 o_valid", 64'(o_valid), 64'd0);
    chk("R1 i_ready", 64'(i_ready), 64'd1);
    lk(pk(8'h12, 16'h1, 16'h2, 16'h3), "R1 lookup after reset");

    // fill table with never-match entries (R9 encoding)
    for (int i = 0; i < N; i++) ent_raw(i, 56'd1, 56'd1, 64'd0, 64'd0);

    // R5: stage enable gates
    ka = pk(8'h21, 16'hBEEF, 16'h0102, 16'h7777);
    ent(5, ka, '1, 64'h0000_0000_0002_0055, 64'h0000_0000_0000_0A30);
    set_dis(0, ~(64'd1 << 5));
    lk(ka, "R5 disabled stage");
    set_ctl(1, 8'h00);
    lk(ka, "R2 R7 exact hit");
    lk(ka ^ 56'h100, "R2 one bit off");

    // R2 don't-care bits
    ent(5, ka, 56'hFF_FFFF_FFFF_FF00, 64'h11, 64'h22);
    lk(ka ^ 56'h0F, "R2 dont care bits");

    // R6 priority, R4 disable
    kb = pk(8'h33, 16'h4444, 16'h5555, 16'h6666);
    ent(10, kb, '1, 64'hA0A0, 64'h0B0B);
    ent(20, kb, 56'h00_0000_0000_00FF, 64'hC0C0, 64'h0D0D);
    set_dis(0, ~((64'd1 << 10) | (64'd1 << 20)));
    lk(kb, "R6 lowest wins");
    set_dis(0, ~(64'd1 << 20));
    lk(kb, "R4 disabled entry skipped");

    // R9 contradictory bit
    ent_raw(30, 56'd1, 56'd1, 64'h1234, 64'h5678);
    set_dis(0, ~(64'd1 << 30));
    lk(pk(8'h01, 16'h0, 16'h0, 16'h0), "R9 both planes set bit1");
    lk(pk(8'h00, 16'h0, 16'h0, 16'h0), "R9 both planes set bit0");
    ent_raw(30, 56'd1, 56'd0, 64'h1234, 64'h5678);
    lk(pk(8'h01, 16'h0, 16'h0, 16'h0), "R2 plane1 only");
    ent_raw(30, 56'd1, 56'd1, 64'd0, 64'd0);

    // R4 first-N across word boundary, R3 addressing
    ent(65, pk(8'h65, 16'h1, 16'h1, 16'h1), '1, 64'h6565, 64'h0650);
    ent(70, pk(8'h70, 16'h1, 16'h1, 16'h1), '1, 64'h7070, 64'h0700);
    ent(100, pk(8'hA0, 16'h1, 16'h1, 16'h1), '1, 64'hA0A0, 64'h0A00);
    set_dis(0, first_n(70, 0));
    set_dis(1, first_n(70, 1));
    lk(pk(8'h65, 16'h1, 16'h1, 16'h1), "R4 entry 65 enabled");
    lk(pk(8'h70, 16'h1, 16'h1, 16'h1), "R4 entry 70 disabled");
    lk(pk(8'hA0, 16'h1, 16'h1, 16'h1), "R3 entry 100 disabled");

    // R8 default error code on miss
    set_ctl(1, 8'hA5);
    lk(pk(8'hEE, 16'h9, 16'h9, 16'h9), "R8 miss default code");

    // R10 back-pressure
    set_dis(1, '1);
    set_dis(0, ~((64'd1 << 5) | (64'd1 << 10)));
    @(negedge clk);
    o_ready = 0; i_valid = 1; {i_dp2, i_dp1, i_dp0, i_state} = kb;
    @(posedge clk);
    @(negedge clk);
    {i_dp2, i_dp1, i_dp0, i_state} = ka;
    chk("R10 i_ready low while held", 64'(i_ready), 64'd0);
    hold0 = o_act0;
    chk("R10 first result", o_act0, 64'hA0A0);
    repeat (3) @(negedge clk);
    chk("R10 held stable", o_act0, hold0);
    chk("R10 held idx", 64'(o_idx), 64'd10);
    chk("R10 still stalled", 64'(i_ready), 64'd0);
    o_ready = 1;
    @(posedge clk);
    @(negedge clk);
    i_valid = 0;
    chk("R10 second result idx", 64'(o_idx), 64'd5);
    chk("R10 second result valid", 64'(o_valid), 64'd1);
    @(negedge clk);
    chk("R10 drained", 64'(o_valid), 64'd0);

    // random phase
    void'($urandom(32'd12345));
    for (int i = 0; i < N; i++) begin
      v = pk(8'($urandom % 4), 16'($urandom % 4), 16'($urandom % 4), 16'($urandom % 4));
      m = pk(8'($urandom % 4), 16'($urandom % 4), 16'($urandom % 4), 16'($urandom % 4));
      ent(i, v, m, {$urandom, $urandom}, {$urandom, $urandom});
    end
    for (int r = 0; r < 6; r++) begin
      set_dis(0, {$urandom, $urandom} | {$urandom, $urandom});
      set_dis(1, {$urandom, $urandom} | {$urandom, $urandom});
      set_ctl((r != 3), 8'($urandom));
      for (int t = 0; t < 50; t++)
        lk(pk(8'($urandom % 4), 16'($urandom % 4), 16'($urandom % 4), 16'($urandom % 4)),
           "R6 R7 R8 random lookup");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", ntot, nbad);
    $finish;
  end
endmodule